// File: doc/BRIEF.md
# Interrupt translator control register file

This block is the memory-mapped control register file of an interrupt translation unit. It holds a control word, a read-only capability word, an identification word and a bank of identification words. It also holds a command-queue base word, the queue's producer (write) and consumer (read) pointers, and a bank of table base words that describe the in-memory translation tables. A host reaches it through a simple request port that carries 4-byte or 8-byte accesses. Every 64-bit register can be reached as one 8-byte access or as two 4-byte halves.

The block decides which registers are writable, and when. Once the unit is enabled, the queue base and the table bases are frozen. Writing the queue base resets both pointers. The consumer pointer can only be written while the chip-level security-disable input is high. Certain status bits are stripped from pointer writes. A write to the control word that leaves the enable bit set produces a one-cycle `enable_pulse`. Downstream logic uses that pulse to capture table and queue parameters. Illegal accesses never stall the port and never return a bus error: they read as zero and pulse `err_pulse`.

The request port has a valid/ready pair. `req_ready` is always high, so the host never sees back-pressure and one request may be presented on every cycle. Each accepted request gets exactly one response, with `rsp_valid` high on the following cycle. There is no ready on the response side: the host must take it in that cycle.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: The size code `req_size` means 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A 4-byte access must have address bits [1:0] zero and an 8-byte access must have bits [2:0] zero. Several accesses are illegal: any other size, a misaligned access, an offset that maps nothing, and an 8-byte access to the 32-bit-only words. An illegal access returns read data zero, changes no register, and pulses `err_pulse` in the response cycle.
- R2: The control word is at offset 0x000 and is 4-byte only. Its reset value is 0x8000_0000, with bit 31 as the quiescent flag. A write ORs the write data into the stored value, so no bit is ever cleared by software. Bit 0 is the enable bit.
- R3: A control-word write after which bit 0 is 1 sets the consumer pointer to zero and drives `enable_pulse` high for exactly the response cycle.
- R4: The queue base word is at 0x010. While the enable bit is 0, an 8-byte write or a write to either 4-byte half updates it and sets both pointers to zero. While the enable bit is 1, such writes change nothing and raise no error.
- R5: The producer pointer is at 0x018 and is always writable. A write that covers the low half clears bit 0, the retry bit, before storing. A write to the upper half (0x01C) changes only bits 63:32.
- R6: The consumer pointer is at 0x020. It accepts writes only while `sec_disable` is 1, and a write covering the low half clears bit 0, the stalled bit. While `sec_disable` is 0, a write is dropped and pulses `err_pulse`.
- R7: Table base word n is at 0x040 + 8*n, for n = 0 to 7. With a 4-byte access, address bit 2 selects the upper half. Bits 58:56 (table type) and 52:48 (entry size minus one) never change on a write. All table base writes are ignored while the enable bit is 1.
- R8: On reset, table base 0 has type 001 and table base 1 has type 100. Both have page-size code 2 in bits 9:8 and an entry-size field of 7. All other table bases reset to zero.
- R9: Three words are read-only, and a write to any of them changes nothing and pulses `err_pulse`:
  - the capability word at 0x008, which reads `TYPE_VAL`;
  - the identification word at 0x004, which reads `IDENT_VAL` and is 4-byte only;
  - the identification bank at 0x0C0 + 4*k, which reads `ID_BASE + k` and is 4-byte only.
- R10: `req_ready` is always 1. Every request gives `rsp_valid` high in the next cycle. A 4-byte read returns its half in `rsp_rdata[31:0]` with the upper bits zero, and a write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Chip-level security disable; allows consumer pointer writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data |
| err_pulse | output | 1 | One-cycle flag for an illegal or refused access |
| enable_pulse | output | 1 | One-cycle flag after a control write that leaves enable set |

## Verification
The assertions assume that the host holds `req_write`, `req_size`, `req_addr` and `req_wdata` steady for the whole cycle in which `req_valid` is high. They also assume that `sec_disable` changes only between requests and not in the middle of one. The bench drives every request on the falling clock edge and holds it for exactly one cycle. It changes `sec_disable` only while no request is outstanding, and it reads the result of each access in the following low phase.

// File: rtl/xlat_regs_pkg.sv
`timescale 1ns/1ps
package xlat_regs_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTL, SEL_IDENT, SEL_IDREG, SEL_TYPE,
    SEL_QBASE, SEL_WPTR, SEL_RPTR, SEL_TBL
  } reg_sel_e;

  localparam logic [1:0] SZ_4B = 2'd2;
  localparam logic [1:0] SZ_8B = 2'd3;

  // qword offsets (byte offset / 8)
  localparam int QW_CTL   = 0;
  localparam int QW_TYPE  = 1;
  localparam int QW_QBASE = 2;
  localparam int QW_WPTR  = 3;
  localparam int QW_RPTR  = 4;
  localparam int QW_TBL   = 8;
  localparam int ID_OFF   = 'hC0;

  localparam int TT_LSB   = 56;
  localparam int ESZ_LSB  = 48;
  localparam int PG_LSB   = 8;
  localparam logic [63:0] TBL_RO_MASK = 64'h071F_0000_0000_0000;
  localparam logic [63:0] PTR_FLAG    = 64'h1;

  localparam logic [2:0] TT_DEV  = 3'b001;
  localparam logic [2:0] TT_COLL = 3'b100;
  localparam logic [1:0] PG_64K  = 2'd2;

  function automatic logic [63:0] tbl_reset(input int idx, input int dev_esz,
                                            input int coll_esz);
    logic [63:0] v;
    logic [4:0]  esz;
    v = '0;
    if (idx == 0 || idx == 1) begin
      esz = (idx == 0) ? 5'(dev_esz - 1) : 5'(coll_esz - 1);
      v[TT_LSB +: 3]  = (idx == 0) ? TT_DEV : TT_COLL;
      v[ESZ_LSB +: 5] = esz;
      v[PG_LSB +: 2]  = PG_64K;
    end
    return v;
  endfunction

endpackage

// File: rtl/xlat_access_decode.sv
`timescale 1ns/1ps
module xlat_access_decode import xlat_regs_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int N_TBL  = 8,
  parameter int N_ID   = 12,
  parameter int TBL_IW = 3,
  parameter int ID_IW  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  output reg_sel_e          sel,
  output logic              full8,
  output logic              hi_half,
  output logic [TBL_IW-1:0] tbl_idx,
  output logic [ID_IW-1:0]  id_idx,
  output logic [63:0]       lane_mask,
  output logic [63:0]       lane_data
);
  localparam int QW = ADDR_W - 3;

  logic [QW-1:0]     qword;
  logic [QW-1:0]     toff;
  logic [ADDR_W-1:0] ioff;
  logic              is4, is8;

  always_comb begin
    is4     = (size == SZ_4B) && (addr[1:0] == 2'b00);
    is8     = (size == SZ_8B) && (addr[2:0] == 3'b000);
    qword   = addr[ADDR_W-1:3];
    hi_half = addr[2];
    full8   = is8;
    toff    = qword - QW'(QW_TBL);
    ioff    = addr - ADDR_W'(ID_OFF);
    tbl_idx = toff[TBL_IW-1:0];
    id_idx  = ioff[ID_IW+1:2];
    sel     = SEL_NONE;
    if (qword == QW'(QW_CTL)) begin
      if (is4) sel = hi_half ? SEL_IDENT : SEL_CTL;
    end else if (is4 || is8) begin
      if (qword == QW'(QW_TYPE))       sel = SEL_TYPE;
      else if (qword == QW'(QW_QBASE)) sel = SEL_QBASE;
      else if (qword == QW'(QW_WPTR))  sel = SEL_WPTR;
      else if (qword == QW'(QW_RPTR))  sel = SEL_RPTR;
      else if (qword >= QW'(QW_TBL) && toff < QW'(N_TBL)) sel = SEL_TBL;
      else if (is4 && addr >= ADDR_W'(ID_OFF) && ioff < ADDR_W'(N_ID * 4))
        sel = SEL_IDREG;
    end
    if (is8) begin
      lane_mask = '1;
      lane_data = wdata;
    end else if (hi_half) begin
      lane_mask = {32'hFFFF_FFFF, 32'h0};
      lane_data = {wdata[31:0], 32'h0};
    end else begin
      lane_mask = {32'h0, 32'hFFFF_FFFF};
      lane_data = {32'h0, wdata[31:0]};
    end
  end

endmodule

// File: rtl/xlat_queue_regs.sv
`timescale 1ns/1ps
module xlat_queue_regs import xlat_regs_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_base,
  input  logic        we_wptr,
  input  logic        we_rptr,
  input  logic        clr_rptr,
  input  logic [63:0] mask,
  input  logic [63:0] data,
  output logic [63:0] base_q,
  output logic [63:0] wptr_q,
  output logic [63:0] rptr_q
);
  logic [63:0] ptr_data;
  assign ptr_data = data & ~PTR_FLAG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (we_base) begin
      base_q <= (base_q & ~mask) | (data & mask);
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (we_wptr) wptr_q <= (wptr_q & ~mask) | (ptr_data & mask);
      if (clr_rptr)     rptr_q <= '0;
      else if (we_rptr) rptr_q <= (rptr_q & ~mask) | (ptr_data & mask);
    end
  end

  AST_QBASE_ZEROES_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    we_base |=> (rptr_q == 64'h0 && wptr_q == 64'h0));  // R4
  AST_WPTR_RETRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wptr && mask[0] && !we_base) |=> !wptr_q[0]);  // R5

endmodule

// File: rtl/xlat_base_tables.sv
`timescale 1ns/1ps
module xlat_base_tables import xlat_regs_pkg::*; #(
  parameter int N_TBL    = 8,
  parameter int TBL_IW   = 3,
  parameter int DEV_ESZ  = 8,
  parameter int COLL_ESZ = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [TBL_IW-1:0]       idx,
  input  logic [63:0]             mask,
  input  logic [63:0]             data,
  output logic [N_TBL-1:0][63:0]  tbl_q
);
  logic [63:0] wmask;
  assign wmask = mask & ~TBL_RO_MASK;

  for (genvar i = 0; i < N_TBL; i++) begin : g_tbl
    localparam logic [63:0] RST_VAL = tbl_reset(i, DEV_ESZ, COLL_ESZ);
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl_q[i] <= RST_VAL;
      else if (we && idx == TBL_IW'(i))
        tbl_q[i] <= (tbl_q[i] & ~wmask) | (data & wmask);
    end
    AST_TBL_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((tbl_q[i] & TBL_RO_MASK) == (RST_VAL & TBL_RO_MASK)));  // R7
  end

endmodule

// File: rtl/xlat_ctrl_regs.sv
`timescale 1ns/1ps
module xlat_ctrl_regs import xlat_regs_pkg::*; #(
  parameter int          ADDR_W    = 12,
  parameter int          N_TBL     = 8,
  parameter int          N_ID      = 12,
  parameter int          DEV_ESZ   = 8,
  parameter int          COLL_ESZ  = 8,
  parameter logic [63:0] TYPE_VAL  = 64'h0000_000F_0010_0001,
  parameter logic [31:0] IDENT_VAL = 32'h0010_043B,
  parameter logic [31:0] ID_BASE   = 32'h0000_00A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_disable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              err_pulse,
  output logic              enable_pulse
);
  localparam int TBL_IW = (N_TBL > 1) ? $clog2(N_TBL) : 1;
  localparam int ID_IW  = (N_ID > 1) ? $clog2(N_ID) : 1;
  localparam logic [31:0] CTL_RST = 32'h8000_0000;

  reg_sel_e            sel;
  logic                full8, hi_half;
  logic [TBL_IW-1:0]   tbl_idx;
  logic [ID_IW-1:0]    id_idx;
  logic [63:0]         lane_mask, lane_data;
  logic [31:0]         ctl_q, ctl_nxt;
  logic [63:0]         qbase_q, wptr_q, rptr_q;
  logic [N_TBL-1:0][63:0] tbl_q;
  logic                wr, ctl_we, en_hit, ro_write, err_d;
  logic [63:0]         rd64, rd_out;

  assign req_ready = 1'b1;

  xlat_access_decode #(
    .ADDR_W(ADDR_W), .N_TBL(N_TBL), .N_ID(N_ID), .TBL_IW(TBL_IW), .ID_IW(ID_IW)
  ) u_dec (
    .addr(req_addr), .size(req_size), .wdata(req_wdata), .sel(sel),
    .full8(full8), .hi_half(hi_half), .tbl_idx(tbl_idx), .id_idx(id_idx),
    .lane_mask(lane_mask), .lane_data(lane_data)
  );

  assign wr      = req_valid && req_write;
  assign ctl_we  = wr && (sel == SEL_CTL);
  assign ctl_nxt = ctl_q | req_wdata[31:0];
  assign en_hit  = ctl_we && ctl_nxt[0];

  xlat_queue_regs u_queue (
    .clk(clk), .rst_n(rst_n),
    .we_base(wr && sel == SEL_QBASE && !ctl_q[0]),
    .we_wptr(wr && sel == SEL_WPTR),
    .we_rptr(wr && sel == SEL_RPTR && sec_disable),
    .clr_rptr(en_hit),
    .mask(lane_mask), .data(lane_data),
    .base_q(qbase_q), .wptr_q(wptr_q), .rptr_q(rptr_q)
  );

  xlat_base_tables #(
    .N_TBL(N_TBL), .TBL_IW(TBL_IW), .DEV_ESZ(DEV_ESZ), .COLL_ESZ(COLL_ESZ)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(wr && sel == SEL_TBL && !ctl_q[0]),
    .idx(tbl_idx), .mask(lane_mask), .data(lane_data), .tbl_q(tbl_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CTL, SEL_IDENT: rd64 = {IDENT_VAL, ctl_q};
      SEL_IDREG:          rd64 = {2{ID_BASE + 32'(id_idx)}};
      SEL_TYPE:           rd64 = TYPE_VAL;
      SEL_QBASE:          rd64 = qbase_q;
      SEL_WPTR:           rd64 = wptr_q;
      SEL_RPTR:           rd64 = rptr_q;
      SEL_TBL:            rd64 = tbl_q[tbl_idx];
      default:            rd64 = '0;
    endcase
    if (req_write || sel == SEL_NONE) rd_out = '0;
    else if (full8)                   rd_out = rd64;
    else if (hi_half)                 rd_out = {32'h0, rd64[63:32]};
    else                              rd_out = {32'h0, rd64[31:0]};
    ro_write = wr && (sel == SEL_TYPE || sel == SEL_IDENT || sel == SEL_IDREG);
    err_d    = req_valid && ((sel == SEL_NONE) || ro_write ||
               (wr && sel == SEL_RPTR && !sec_disable));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q        <= CTL_RST;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      err_pulse    <= 1'b0;
      enable_pulse <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_nxt;
      rsp_valid    <= req_valid;
      rsp_rdata    <= req_valid ? rd_out : '0;
      err_pulse    <= err_d;
      enable_pulse <= en_hit;
    end
  end

  AST_ALWAYS_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R10
  AST_BAD_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel == SEL_NONE) |=> (err_pulse && rsp_rdata == 64'h0));  // R1
  AST_CTL_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ((ctl_q & $past(ctl_q)) == $past(ctl_q)));  // R2
  AST_EN_PULSE_CLEARS_RPTR: assert property (@(posedge clk) disable iff (!rst_n)
    enable_pulse |-> (ctl_q[0] && rptr_q == 64'h0));  // R3
  AST_LOCKED_QBASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_QBASE && ctl_q[0]) |=> $stable(qbase_q));  // R4
  AST_RPTR_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_RPTR && !sec_disable) |=> ($stable(rptr_q) && err_pulse));  // R6
  AST_TBL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_TBL && ctl_q[0]) |=> $stable(tbl_q));  // R7

endmodule

// File: tb/xlat_ctrl_regs_bench.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_bench;
  localparam logic [11:0] A_CTL = 12'h000, A_IDENT = 12'h004, A_TYPE = 12'h008,
                          A_QB = 12'h010, A_WP = 12'h018, A_RP = 12'h020,
                          A_TBL = 12'h040, A_ID = 12'h0C0;
  localparam logic [63:0] TYPE_EXP = 64'h0000_000F_0010_0001;

  logic clk = 1'b0, rst_n = 1'b0, sec_disable = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, err_pulse, enable_pulse;
  logic [63:0] rsp_rdata;
  logic [63:0] r_data;
  logic r_err, r_en, r_valid;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_ctrl_regs u_xlat_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .enable_pulse(enable_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                     input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    r_data = rsp_rdata; r_err = err_pulse; r_en = enable_pulse; r_valid = rsp_valid;
  endtask

  task automatic t_reset_state();
    acc(0, 2'd2, A_CTL, 0);
    chk("R2 ctl reset", r_data, 64'h8000_0000);
    chk("R10 rsp_valid", {63'h0, r_valid}, 64'h1);
    chk("R10 req_ready", {63'h0, req_ready}, 64'h1);
    acc(0, 2'd3, A_TBL, 0);
    chk("R8 tbl0 reset", r_data, 64'h0107_0000_0000_0200);
    acc(0, 2'd3, A_TBL + 12'h8, 0);
    chk("R8 tbl1 reset", r_data, 64'h0407_0000_0000_0200);
    acc(0, 2'd3, A_TBL + 12'h10, 0);
    chk("R8 tbl2 reset", r_data, 64'h0);
    acc(0, 2'd3, A_RP, 0);
    chk("R6 rptr reset", r_data, 64'h0);
  endtask

  task automatic t_read_only();
    acc(1, 2'd3, A_TYPE, 64'h1234);
    chk("R9 type write err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd3, A_TYPE, 0);
    chk("R9 type value", r_data, TYPE_EXP);
    acc(0, 2'd2, A_TYPE + 12'h4, 0);
    chk("R10 type upper half", r_data, {32'h0, TYPE_EXP[63:32]});
    acc(1, 2'd2, A_IDENT, 64'h5);
    chk("R9 ident write err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd2, A_IDENT, 0);
    chk("R9 ident value", r_data, 64'h0010_043B);
    acc(0, 2'd2, A_ID + 12'hC, 0);
    chk("R9 id word 3", r_data, 64'hA3);
    acc(1, 2'd2, A_ID, 64'h77);
    chk("R9 id write err", {63'h0, r_err}, 64'h1);
  endtask

  task automatic t_illegal();
    acc(0, 2'd0, A_CTL, 0);
    chk("R1 byte read data", r_data, 0);
    chk("R1 byte read err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd2, 12'h100, 0);
    chk("R1 unmapped err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd3, A_CTL, 0);
    chk("R1 ctl 8-byte data", r_data, 0);
    chk("R1 ctl 8-byte err", {63'h0, r_err}, 64'h1);
    acc(1, 2'd3, 12'h014, 64'hFFFF);
    chk("R1 misaligned err", {63'h0, r_err}, 64'h1);
    acc(1, 2'd1, A_QB, 64'hBEEF);
    chk("R1 halfword write err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd3, A_QB, 0);
    chk("R1 halfword write ignored", r_data, 0);
    acc(0, 2'd2, A_CTL, 0);
    chk("R1 good read no err", {63'h0, r_err}, 64'h0);
  endtask

  task automatic t_write_ptr();
    acc(1, 2'd3, A_WP, 64'hFF);
    acc(0, 2'd3, A_WP, 0);
    chk("R5 retry cleared full", r_data, 64'hFE);
    acc(1, 2'd2, A_WP + 12'h4, 64'h5);
    acc(0, 2'd3, A_WP, 0);
    chk("R5 upper half", r_data, 64'h0000_0005_0000_00FE);
    acc(1, 2'd2, A_WP, 64'h11);
    acc(0, 2'd3, A_WP, 0);
    chk("R5 low half clears retry", r_data, 64'h0000_0005_0000_0010);
  endtask

  task automatic t_read_ptr();
    sec_disable = 1'b0;
    acc(1, 2'd3, A_RP, 64'h40);
    chk("R6 refused err", {63'h0, r_err}, 64'h1);
    acc(0, 2'd3, A_RP, 0);
    chk("R6 refused unchanged", r_data, 0);
    sec_disable = 1'b1;
    acc(1, 2'd3, A_RP, 64'h41);
    chk("R6 accepted no err", {63'h0, r_err}, 64'h0);
    acc(0, 2'd3, A_RP, 0);
    chk("R6 stalled cleared", r_data, 64'h40);
    sec_disable = 1'b0;
  endtask

  task automatic t_queue_base();
    acc(1, 2'd2, A_QB, 64'hABCD_0000);
    acc(0, 2'd3, A_QB, 0);
    chk("R4 qbase low half", r_data, 64'hABCD_0000);
    acc(0, 2'd3, A_WP, 0);
    chk("R4 wptr zeroed", r_data, 0);
    acc(0, 2'd3, A_RP, 0);
    chk("R4 rptr zeroed", r_data, 0);
  endtask

  task automatic t_tables();
    acc(1, 2'd3, A_TBL + 12'h10, '1);
    acc(0, 2'd3, A_TBL + 12'h10, 0);
    chk("R7 tbl2 ro fields", r_data, 64'hF8E0_FFFF_FFFF_FFFF);
    acc(1, 2'd2, A_TBL + 12'h4, 64'hFFFF_FFFF);
    acc(0, 2'd3, A_TBL, 0);
    chk("R7 tbl0 upper half", r_data, 64'hF9E7_FFFF_0000_0200);
    acc(0, 2'd2, A_TBL + 12'h4, 0);
    chk("R7 tbl0 upper read", r_data, 64'hF9E7_FFFF);
  endtask

  task automatic t_enable();
    acc(1, 2'd2, A_CTL, 64'h2);
    chk("R3 no pulse without enable", {63'h0, r_en}, 64'h0);
    acc(1, 2'd2, A_CTL, 64'h0);
    acc(0, 2'd2, A_CTL, 0);
    chk("R2 bits sticky", r_data, 64'h8000_0002);
    sec_disable = 1'b1;
    acc(1, 2'd3, A_RP, 64'h80);
    sec_disable = 1'b0;
    acc(1, 2'd2, A_CTL, 64'h1);
    chk("R3 enable pulse", {63'h0, r_en}, 64'h1);
    acc(0, 2'd2, A_CTL, 0);
    chk("R2 ctl after enable", r_data, 64'h8000_0003);
    chk("R3 pulse one cycle", {63'h0, r_en}, 64'h0);
    acc(0, 2'd3, A_RP, 0);
    chk("R3 rptr cleared", r_data, 0);
    acc(1, 2'd3, A_QB, 64'h5555);
    chk("R4 locked no err", {63'h0, r_err}, 64'h0);
    acc(0, 2'd3, A_QB, 0);
    chk("R4 qbase locked", r_data, 64'hABCD_0000);
    acc(1, 2'd3, A_TBL + 12'h10, 64'h0);
    acc(0, 2'd3, A_TBL + 12'h10, 0);
    chk("R7 tbl locked", r_data, 64'hF8E0_FFFF_FFFF_FFFF);
    acc(1, 2'd3, A_WP, 64'h33);
    acc(0, 2'd3, A_WP, 0);
    chk("R5 wptr writable enabled", r_data, 64'h32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_read_only();
    t_illegal();
    t_write_ptr();
    t_read_ptr();
    t_queue_base();
    t_tables();
    t_enable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule